// File: doc/BRIEF.md
# Management Serial Bus Frame Decoder with Software Clocking

This block is the target side of a two-wire management bus (a clock line and a bidirectional data line) carrying clause-22 style frames. Software does not get a clock generator. It moves the bus by writing a small control register whose bits set the clock level, the data value and whether that value is driven. The block watches these writes. It decodes the frame that the writes build up and answers on the data line. A status register reads back the resolved level of the data line and a sticky protocol-error flag.

A decoded read fetches a 16-bit value from a PHY register port and shifts it out on the data line, one bit per falling clock edge. A decoded write collects 16 bits and delivers them to the same port as a one-cycle request. A presence mask states which of the 32 PHY addresses have a device behind them. A read of an empty address returns all ones and issues no request. A write to an empty address issues nothing.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: Control writes use bit 2 as the clock level, bit 1 as the drive enable and bit 0 as the driven value. The data line resolves as follows: while the block drives, it takes the block's bit. Otherwise it takes bit 0 if bit 1 of the last write was set, and 1 (pull-up) if not. Status bit 0 is that level and status bit 1 is the error flag.
- R2: The decoder advances by one edge only on a control write whose bit 2 differs from the previous value of bit 2. Any other write changes only the line level. The PHY address, the register number and the status bits stay unchanged across cycles without a write.
- R3: The data line is sampled on rising edges. A preamble is at least 32 consecutive ones. A 0 received after fewer ones restarts the hunt. A 0 received after 32 or more ones is the first start bit.
- R4: The bit after the first start bit should be 1. If it is 0, status bit 1 is set and stays set until reset, and decoding of the frame continues.
- R5: After the start field come a 2-bit opcode, a 5-bit PHY address and a 5-bit register number, each received MSB first, followed by two turnaround edges.
- R6: For opcode binary 10 (read), the block drives the line to 0 at the second turnaround rising edge. In that same cycle it pulses phy_rd_req for one cycle with phy_addr and phy_reg valid, and samples phy_rdata in that cycle.
- R7: Read data leaves MSB first. Each falling edge in the data phase presents the next bit on the line.
- R8: A read of an address whose presence bit is 0 returns 0xFFFF and raises no phy_rd_req.
- R9: For any other opcode, 16 data bits are taken MSB first on rising edges. After the 16th bit, phy_wr_req pulses for one cycle carrying address, register and data, but only when the address is present.
- R10: At the 16th data rising edge the block stops driving the line and goes back to hunting for a preamble.
- R11: After reset the line reads 1, the error flag is 0 and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | Control write data: clock, drive enable, value |
| stat_rdata | output | 2 | Status: bit 1 error flag, bit 0 line level |
| phy_present | input | 32 | One bit per PHY address, 1 when a device is attached |
| phy_rd_req | output | 1 | One-cycle PHY register read request |
| phy_wr_req | output | 1 | One-cycle PHY register write request |
| phy_addr | output | 5 | Decoded PHY address |
| phy_reg | output | 5 | Decoded register number |
| phy_wdata | output | 16 | Write data collected from the frame |
| phy_rdata | input | 16 | Read data, valid while phy_rd_req is high |

## Verification
The hardest situation to reach from the ports is a control write that leaves the clock level unchanged but changes the driven value in the middle of a frame. If the decoder were to treat that write as an edge, every later field would be shifted by one bit. The bench enables a noise mode in which every rising-edge write is followed by a write at the same clock level with the opposite data value. It checks that status bit 0 follows the software value, and then that the write request still arrives with the expected address, register and data. A preamble one bit short, a read of an empty address and a frame whose second start bit is 0 cover the other boundaries.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  typedef enum logic [2:0] {
    ST_HUNT  = 3'd0,
    ST_START = 3'd1,
    ST_OPC   = 3'd2,
    ST_PADDR = 3'd3,
    ST_RADDR = 3'd4,
    ST_TURN  = 3'd5,
    ST_DATA  = 3'd6
  } dec_state_e;

  localparam logic [1:0] OPC_READ = 2'b10;

endpackage

// File: rtl/mdio_bb_port.sv
module mdio_bb_port (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_i,
  input  logic [2:0] wdata_i,
  input  logic       slv_drv_i,
  input  logic       slv_bit_i,
  output logic       step_o,
  output logic       rise_o,
  output logic       sample_o,
  output logic       line_o
);

  logic mdc_q, oe_q, val_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mdc_q <= 1'b0;
      oe_q  <= 1'b0;
      val_q <= 1'b1;
    end else if (wr_i) begin
      mdc_q <= wdata_i[2];
      oe_q  <= wdata_i[1];
      val_q <= wdata_i[0];
    end
  end

  // an edge exists only when the written clock level differs from the held one
  assign step_o = wr_i && (wdata_i[2] != mdc_q);
  assign rise_o = wdata_i[2];

  // level seen at this edge: block first, then the new software value, else pull-up
  assign sample_o = slv_drv_i ? slv_bit_i : (wdata_i[1] ? wdata_i[0] : 1'b1);
  assign line_o   = slv_drv_i ? slv_bit_i : (oe_q ? val_q : 1'b1);

endmodule

// File: rtl/mdio_frame_dec.sv
module mdio_frame_dec #(
  parameter int PRE_LEN = 32,
  parameter int AW      = 5,
  parameter int RW      = 5,
  parameter int DW      = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step_i,
  input  logic                 rise_i,
  input  logic                 smp_i,
  input  logic [(1<<AW)-1:0]   present_i,
  input  logic [DW-1:0]        rdata_i,
  output logic                 slv_drv_o,
  output logic                 slv_bit_o,
  output logic                 err_o,
  output logic                 rd_req_o,
  output logic                 wr_req_o,
  output logic [AW-1:0]        addr_o,
  output logic [RW-1:0]        reg_o,
  output logic [DW-1:0]        wdata_o
);
  import mdio_pkg::*;

  localparam int CMAX = (PRE_LEN > DW) ? PRE_LEN : DW;
  localparam int CW   = $clog2(CMAX + 1);

  dec_state_e     st_q;
  logic [CW-1:0]  cnt_q;
  logic [1:0]     opc_q;
  logic [AW-1:0]  addr_q;
  logic [RW-1:0]  reg_q;
  logic [DW-1:0]  sh_q;
  logic           is_rd_q, pend_q, pres_q;
  logic           drv_q, bit_q, err_q, wr_q;
  logic [DW-1:0]  wd_q;
  logic [DW-1:0]  fetched, eff;

  assign fetched = pres_q ? rdata_i : {DW{1'b1}};
  // a falling edge in the fetch cycle must see the value being fetched
  assign eff     = pend_q ? fetched : sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_HUNT;
      cnt_q   <= '0;
      opc_q   <= '0;
      addr_q  <= '0;
      reg_q   <= '0;
      sh_q    <= '0;
      is_rd_q <= 1'b0;
      pend_q  <= 1'b0;
      pres_q  <= 1'b0;
      drv_q   <= 1'b0;
      bit_q   <= 1'b1;
      err_q   <= 1'b0;
      wr_q    <= 1'b0;
      wd_q    <= '0;
    end else begin
      pend_q <= 1'b0;
      wr_q   <= 1'b0;
      if (pend_q) sh_q <= fetched;
      if (step_i) begin
        if (rise_i) begin
          unique case (st_q)
            ST_HUNT: begin
              if (smp_i) begin
                if (cnt_q < CW'(PRE_LEN)) cnt_q <= cnt_q + 1'b1;
              end else if (cnt_q >= CW'(PRE_LEN)) begin
                st_q  <= ST_START;
                cnt_q <= '0;
              end else begin
                cnt_q <= '0;
              end
            end
            ST_START: begin
              if (!smp_i) err_q <= 1'b1;
              st_q  <= ST_OPC;
              cnt_q <= '0;
            end
            ST_OPC: begin
              opc_q <= {opc_q[0], smp_i};
              if (cnt_q == CW'(1)) begin
                st_q  <= ST_PADDR;
                cnt_q <= '0;
              end else cnt_q <= cnt_q + 1'b1;
            end
            ST_PADDR: begin
              addr_q <= {addr_q[AW-2:0], smp_i};
              if (cnt_q == CW'(AW-1)) begin
                st_q  <= ST_RADDR;
                cnt_q <= '0;
              end else cnt_q <= cnt_q + 1'b1;
            end
            ST_RADDR: begin
              reg_q <= {reg_q[RW-2:0], smp_i};
              if (cnt_q == CW'(RW-1)) begin
                st_q  <= ST_TURN;
                cnt_q <= '0;
              end else cnt_q <= cnt_q + 1'b1;
            end
            ST_TURN: begin
              if (cnt_q == CW'(1)) begin
                st_q  <= ST_DATA;
                cnt_q <= '0;
                if (opc_q == OPC_READ) begin
                  is_rd_q <= 1'b1;
                  drv_q   <= 1'b1;
                  bit_q   <= 1'b0;
                  pend_q  <= 1'b1;
                  pres_q  <= present_i[addr_q];
                end
              end else cnt_q <= cnt_q + 1'b1;
            end
            ST_DATA: begin
              if (!is_rd_q) sh_q <= {sh_q[DW-2:0], smp_i};
              if (cnt_q == CW'(DW-1)) begin
                st_q    <= ST_HUNT;
                cnt_q   <= '0;
                drv_q   <= 1'b0;
                is_rd_q <= 1'b0;
                if (!is_rd_q) begin
                  wr_q <= present_i[addr_q];
                  wd_q <= {sh_q[DW-2:0], smp_i};
                end
              end else cnt_q <= cnt_q + 1'b1;
            end
            default: st_q <= ST_HUNT;
          endcase
        end else if (st_q == ST_DATA && is_rd_q) begin
          bit_q <= eff[DW-1];
          sh_q  <= {eff[DW-2:0], 1'b0};
        end
      end
    end
  end

  assign slv_drv_o = drv_q;
  assign slv_bit_o = bit_q;
  assign err_o     = err_q;
  assign rd_req_o  = pend_q && pres_q;
  assign wr_req_o  = wr_q;
  assign addr_o    = addr_q;
  assign reg_o     = reg_q;
  assign wdata_o   = wd_q;

endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave #(
  parameter int PRE_LEN = 32,
  parameter int AW      = 5,
  parameter int RW      = 5,
  parameter int DW      = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ctl_wr,
  input  logic [2:0]          ctl_wdata,
  output logic [1:0]          stat_rdata,
  input  logic [(1<<AW)-1:0]  phy_present,
  output logic                phy_rd_req,
  output logic                phy_wr_req,
  output logic [AW-1:0]       phy_addr,
  output logic [RW-1:0]       phy_reg,
  output logic [DW-1:0]       phy_wdata,
  input  logic [DW-1:0]       phy_rdata
);

  logic step, rise, smp, line, slv_drv, slv_bit, err;

  mdio_bb_port u_port (
    .clk       (clk),
    .rst       (rst),
    .wr_i      (ctl_wr),
    .wdata_i   (ctl_wdata),
    .slv_drv_i (slv_drv),
    .slv_bit_i (slv_bit),
    .step_o    (step),
    .rise_o    (rise),
    .sample_o  (smp),
    .line_o    (line)
  );

  mdio_frame_dec #(
    .PRE_LEN (PRE_LEN),
    .AW      (AW),
    .RW      (RW),
    .DW      (DW)
  ) u_dec (
    .clk       (clk),
    .rst       (rst),
    .step_i    (step),
    .rise_i    (rise),
    .smp_i     (smp),
    .present_i (phy_present),
    .rdata_i   (phy_rdata),
    .slv_drv_o (slv_drv),
    .slv_bit_o (slv_bit),
    .err_o     (err),
    .rd_req_o  (phy_rd_req),
    .wr_req_o  (phy_wr_req),
    .addr_o    (phy_addr),
    .reg_o     (phy_reg),
    .wdata_o   (phy_wdata)
  );

  assign stat_rdata = {err, line};

endmodule

// File: rtl/mdio_mgmt_slave_chk.sv
module mdio_mgmt_slave_chk #(
  parameter int AW = 5,
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          ctl_wr,
  input logic [1:0]    stat_rdata,
  input logic          phy_rd_req,
  input logic          phy_wr_req,
  input logic [AW-1:0] phy_addr,
  input logic [RW-1:0] phy_reg
);

  AST_NO_STEP_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    !ctl_wr |=> ($stable(phy_addr) && $stable(phy_reg) && $stable(stat_rdata))); // R2

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    stat_rdata[1] |=> stat_rdata[1]); // R4

  AST_RD_TAKES_LINE: assert property (@(posedge clk) disable iff (rst)
    $rose(phy_rd_req) |-> (stat_rdata[0] == 1'b0)); // R6

  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    phy_rd_req |=> !phy_rd_req); // R6

  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    phy_wr_req |=> !phy_wr_req); // R9

  AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    phy_wr_req |-> !phy_rd_req); // R9

endmodule

bind mdio_mgmt_slave mdio_mgmt_slave_chk #(.AW(AW), .RW(RW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ctl_wr     (ctl_wr),
  .stat_rdata (stat_rdata),
  .phy_rd_req (phy_rd_req),
  .phy_wr_req (phy_wr_req),
  .phy_addr   (phy_addr),
  .phy_reg    (phy_reg)
);

// File: tb/mdio_mgmt_slave_bench.sv
module mdio_mgmt_slave_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_wr = 1'b0;
  logic [2:0]  ctl_wdata = 3'b000;
  logic [1:0]  stat_rdata;
  logic [31:0] phy_present = 32'h0000_0108;
  logic        phy_rd_req, phy_wr_req;
  logic [4:0]  phy_addr, phy_reg;
  logic [15:0] phy_wdata, phy_rdata;

  int checks = 0;
  int errors = 0;
  int rd_seen = 0;
  bit noise = 1'b0;
  logic [25:0] exp_q[$];

  always #2.5 clk = ~clk;

  mdio_mgmt_slave u_mdio_mgmt_slave (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .stat_rdata(stat_rdata), .phy_present(phy_present),
    .phy_rd_req(phy_rd_req), .phy_wr_req(phy_wr_req),
    .phy_addr(phy_addr), .phy_reg(phy_reg),
    .phy_wdata(phy_wdata), .phy_rdata(phy_rdata)
  );

  function automatic logic [15:0] reg_val(logic [4:0] a, logic [4:0] r);
    return {a, r, 6'b101010};
  endfunction

  assign phy_rdata = phy_rd_req ? reg_val(phy_addr, phy_reg) : 16'h0000;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected write items as the design raises requests
  always @(negedge clk) begin
    if (!rst && phy_rd_req) rd_seen++;
    if (!rst && phy_wr_req) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R9 actual=%0h expected=none", {phy_addr, phy_reg, phy_wdata});
      end else begin
        logic [25:0] e;
        e = exp_q.pop_front();
        if ({phy_addr, phy_reg, phy_wdata} !== e) begin
          errors++;
          $display("FAIL R9 actual=%0h expected=%0h", {phy_addr, phy_reg, phy_wdata}, e);
        end
      end
    end
  end

  task automatic ctl(bit mdc, bit oe, bit val);
    @(negedge clk);
    ctl_wr = 1'b1;
    ctl_wdata = {mdc, oe, val};
    @(negedge clk);
    ctl_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_bit(bit b);
    ctl(1'b0, 1'b1, b);
    ctl(1'b1, 1'b1, b);
    if (noise) begin
      ctl(1'b1, 1'b1, ~b);
      check("R1 R2 stepless write sets line", {31'd0, stat_rdata[0]}, {31'd0, ~b});
    end
  endtask

  task automatic frame(int pre, bit s1, logic [1:0] opc, logic [4:0] a,
                       logic [4:0] r, logic [15:0] d, output logic [15:0] got);
    got = '0;
    for (int i = 0; i < pre; i++) send_bit(1'b1);
    send_bit(1'b0);
    send_bit(s1);
    for (int i = 1; i >= 0; i--) send_bit(opc[i]);
    for (int i = 4; i >= 0; i--) send_bit(a[i]);
    for (int i = 4; i >= 0; i--) send_bit(r[i]);
    if (opc == 2'b10) begin
      ctl(1'b0, 1'b0, 1'b0); ctl(1'b1, 1'b0, 1'b0);
      ctl(1'b0, 1'b0, 1'b0); ctl(1'b1, 1'b0, 1'b0);
      check("R6 line held at 0 after turnaround", {31'd0, stat_rdata[0]}, 32'd0);
      for (int i = 15; i >= 0; i--) begin
        ctl(1'b0, 1'b0, 1'b0);
        got[i] = stat_rdata[0];
        ctl(1'b1, 1'b0, 1'b0);
      end
      check("R10 line released after data", {31'd0, stat_rdata[0]}, 32'd1);
    end else begin
      send_bit(1'b1);
      send_bit(1'b0);
      for (int i = 15; i >= 0; i--) send_bit(d[i]);
    end
    ctl(1'b0, 1'b1, 1'b1);
  endtask

  initial begin
    logic [15:0] got;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11 reset status", {30'd0, stat_rdata}, 32'h1);
    check("R11 no requests", {30'd0, phy_rd_req, phy_wr_req}, 32'd0);

    ctl(1'b0, 1'b1, 1'b0);
    check("R1 software drives 0", {31'd0, stat_rdata[0]}, 32'd0);
    ctl(1'b0, 1'b0, 1'b0);
    check("R1 pull-up when not driving", {31'd0, stat_rdata[0]}, 32'd1);

    frame(32, 1'b1, 2'b10, 5'd3, 5'd5, 16'h0, got);
    check("R5 R6 R7 read present PHY", {16'd0, got}, {16'd0, reg_val(5'd3, 5'd5)});
    check("R6 one read request", rd_seen, 1);

    exp_q.push_back({5'd3, 5'd9, 16'hA5C3});
    frame(32, 1'b1, 2'b01, 5'd3, 5'd9, 16'hA5C3, got);
    check("R9 write delivered", exp_q.size(), 0);

    frame(40, 1'b1, 2'b10, 5'd7, 5'd2, 16'h0, got);
    check("R8 absent read all ones", {16'd0, got}, 32'h0000_FFFF);
    check("R8 no request for absent", rd_seen, 1);

    frame(32, 1'b1, 2'b01, 5'd7, 5'd1, 16'h1234, got);
    check("R9 absent write ignored", exp_q.size(), 0);

    frame(31, 1'b1, 2'b01, 5'd8, 5'd4, 16'h0F0F, got);
    check("R3 short preamble ignored", exp_q.size(), 0);

    exp_q.push_back({5'd8, 5'd17, 16'h5A3C});
    frame(32, 1'b1, 2'b01, 5'd8, 5'd17, 16'h5A3C, got);
    check("R3 exact preamble accepted", exp_q.size(), 0);

    noise = 1'b1;
    exp_q.push_back({5'd8, 5'd30, 16'hC001});
    frame(32, 1'b1, 2'b01, 5'd8, 5'd30, 16'hC001, got);
    noise = 1'b0;
    check("R2 stepless writes do not advance", exp_q.size(), 0);
    check("R4 no error yet", {31'd0, stat_rdata[1]}, 32'd0);

    exp_q.push_back({5'd3, 5'd12, 16'h00FF});
    frame(32, 1'b0, 2'b01, 5'd3, 5'd12, 16'h00FF, got);
    check("R4 error flag set", {31'd0, stat_rdata[1]}, 32'd1);
    check("R4 decoding continued", exp_q.size(), 0);
    repeat (3) @(negedge clk);
    check("R4 error flag sticky", {31'd0, stat_rdata[1]}, 32'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule